// File: doc/BRIEF.md
# Shift-Tolerant Key Correlation Authenticator

This block decides whether a freshly measured binary key belongs to the same device as an enrolled reference key, even when the fresh key is slid along its bit axis by some tens of positions (for instance by a temperature change of the measured part). Software loads both keys into two internal word memories through a single write port. It then pulses a start input. The block sweeps every bit offset in a symmetric window around zero. For each offset it scores the overlapping bits as a bipolar correlation, in which an agreeing pair counts +1 and a disagreeing pair counts −1.

The strongest score is normalised to the full key length and reported as a signed Q1.15 value, together with the offset where it occurred. A second figure of merit is also produced: the smallest fractional Hamming distance seen over the same offsets. The peak score is compared against a programmable threshold to raise an authentic flag. Keys enter 32 bits per write and are processed 32 bits per cycle.

Top module: `keycorr_auth`

## Requirements
- R1: A write with `wr_sel_i` = 0 stores word `wr_addr_i` of the enrolled key, and a write with `wr_sel_i` = 1 stores the same word of the test key. Bit j of word w is key bit 32·w + j.
- R2: For an offset m, enrolled bit n is paired with test bit n + m for every n where both indices lie inside the key. The raw sum for that offset is the count of equal pairs minus the count of unequal pairs.
- R3: Offsets run from −MAX_LAG to +MAX_LAG, with a default MAX_LAG of 72, which covers a drift of 70 bits either way. `lag_o` reports, in two's complement, the offset of the largest raw sum.
- R4: `score_o` is floor(sum·32768 / KEY_BITS) for the winning sum, as signed Q1.15, with +1.0 saturated to 0x7FFF. Identical keys give 0x7FFF. A complemented key at offset 0 gives 0x8000.
- R5: When several offsets share the largest sum, the one of smallest magnitude wins. Between two offsets of equal magnitude, the negative one wins.
- R6: `hd_o` is the minimum over all offsets of floor(mismatches·32768 / overlap), where overlap = KEY_BITS − |m|. It is unsigned, and 0x8000 means 1.0.
- R7: `auth_o` is 1 exactly when the signed `score_o` is greater than or equal to the signed Q1.15 threshold captured from `thr_i` at start. A threshold of 0.25 is written 0x2000.
- R8: A start sampled while idle raises `busy_o` after that edge. The results appear with a one-cycle `valid_o` pulse exactly (2·MAX_LAG+1)·(KEY_BITS/32+3)+18 cycles after the start edge. `busy_o` drops on that same edge, and the result outputs hold until the next pulse.
- R9: While `busy_o` is high, a start is ignored and key writes are dropped.
- R10: After reset, `busy_o`, `valid_o`, `auth_o`, `score_o`, `lag_o` and `hd_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Key word write strobe |
| wr_sel_i | input | 1 | 0 enrolled key, 1 test key |
| wr_addr_i | input | 5 | Word index within the key |
| wr_data_i | input | 32 | Key word, bit j = key bit 32·w + j |
| thr_i | input | 16 | Signed Q1.15 decision threshold |
| start_i | input | 1 | Launch a sweep when idle |
| busy_o | output | 1 | Sweep in progress |
| valid_o | output | 1 | One-cycle result strobe |
| auth_o | output | 1 | Peak score reached threshold |
| score_o | output | 16 | Peak normalised correlation, signed Q1.15 |
| lag_o | output | 8 | Offset of the peak, signed |
| hd_o | output | 16 | Minimum fractional Hamming distance, unsigned, 0x8000 = 1.0 |

## Verification
The busy flag is due one edge after an accepted start. The result pulse and the fall of busy are due a fixed count of edges later, and that count follows only from the key length and the offset window. The bench runs a behavioural model of this timing that counts from the start edge. It compares busy and valid against the model on every falling clock edge, so a result that comes one cycle early or late is caught. Score, offset, Hamming distance and the authentic flag are checked at the falling edge inside the model's valid cycle. Their expected values come from a brute-force offset sweep over the bench's own copy of the keys.

// File: rtl/keycorr_pkg.sv
package keycorr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DRAIN,
    ST_CLOSE,
    ST_DIV,
    ST_FIN
  } kc_state_e;

  localparam int SCORE_W = 16;
  localparam int DIV_STEPS = 16;
endpackage

// File: rtl/keycorr_bitmem.sv
module keycorr_bitmem #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/keycorr_lagslice.sv
module keycorr_lagslice #(
  parameter int WB  = 32,
  parameter int AW  = 5,
  parameter int CW  = 11,
  parameter int SW  = 5,
  parameter int PCW = 6
) (
  input  logic [WB-1:0]  x_word,
  input  logic [WB-1:0]  y_hi,
  input  logic [WB-1:0]  y_lo,
  input  logic [SW-1:0]  shamt,
  input  logic [AW-1:0]  w_idx,
  input  logic [CW-1:0]  lo,
  input  logic [CW-1:0]  hi,
  output logic [PCW-1:0] mism
);
  logic [2*WB-1:0] cat_w;
  logic [WB-1:0]   win_w;
  logic [WB-1:0]   keep_w;
  logic [WB-1:0]   diff_w;

  // funnel: pick WB test bits starting at bit offset shamt
  assign cat_w = {y_hi, y_lo};
  assign win_w = WB'(cat_w >> shamt);

  genvar i;
  for (i = 0; i < WB; i++) begin : g_keep
    localparam logic [SW-1:0] IB = SW'(i);
    logic [CW-1:0] pos;
    assign pos       = CW'({w_idx, IB});
    assign keep_w[i] = (pos >= lo) && (pos < hi);
  end

  assign diff_w = (x_word ^ win_w) & keep_w;

  always_comb begin
    mism = '0;
    for (int k = 0; k < WB; k++) mism = mism + PCW'(diff_w[k]);
  end
endmodule

// File: rtl/keycorr_fracdiv.sv
module keycorr_fracdiv #(
  parameter int CW = 11,
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [CW-1:0] num,
  input  logic [CW-1:0] den,
  output logic [QW-1:0] quot
);
  logic [CW:0] rem_q;
  logic        fit;
  logic [CW:0] nxt;

  assign fit = rem_q >= {1'b0, den};
  assign nxt = fit ? rem_q - {1'b0, den} : rem_q;

  // restoring fraction division, first bit weighs 2^(QW-1)
  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quot  <= '0;
    end else if (load) begin
      rem_q <= {1'b0, num};
      quot  <= '0;
    end else if (step) begin
      rem_q <= nxt << 1;
      quot  <= {quot[QW-2:0], fit};
    end
  end
endmodule

// File: rtl/keycorr_auth.sv
module keycorr_auth
  import keycorr_pkg::*;
#(
  parameter int KEY_BITS  = 1024,
  parameter int MAX_LAG   = 72,
  parameter int WORD_BITS = 32,
  localparam int WORDS = KEY_BITS / WORD_BITS,
  localparam int AW    = $clog2(WORDS),
  localparam int SW    = $clog2(WORD_BITS),
  localparam int LW    = (($clog2(MAX_LAG + 1) + 1) > (SW + 1)) ? ($clog2(MAX_LAG + 1) + 1) : (SW + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en_i,
  input  logic                 wr_sel_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [WORD_BITS-1:0] wr_data_i,
  input  logic [SCORE_W-1:0]   thr_i,
  input  logic                 start_i,
  output logic                 busy_o,
  output logic                 valid_o,
  output logic                 auth_o,
  output logic [SCORE_W-1:0]   score_o,
  output logic [LW-1:0]        lag_o,
  output logic [SCORE_W-1:0]   hd_o
);
  localparam int CW    = $clog2(KEY_BITS + 1);
  localparam int LOG_L = $clog2(KEY_BITS);
  localparam int SUMW  = CW + 2;
  localparam int PCW   = $clog2(WORD_BITS + 1);
  localparam int SCW   = SUMW + 16;
  localparam logic [AW:0]           T_LAST = (AW + 1)'(WORDS);
  localparam logic signed [LW-1:0]  LAG_HI = LW'(MAX_LAG);
  localparam logic signed [LW-1:0]  LAG_LO = LW'(-MAX_LAG);
  localparam logic [CW-1:0]         L_CW   = CW'(KEY_BITS);
  localparam logic signed [SCW-1:0] SAT_HI = SCW'(32767);

  function automatic logic [LW-1:0] mag(input logic signed [LW-1:0] v);
    return (v < 0) ? -v : v;
  endfunction

  kc_state_e state_q;
  logic [AW:0]             t_q;
  logic signed [LW-1:0]    lag_q;
  logic                    arr_q, cons_q, first_q;
  logic [AW-1:0]           w_q;
  logic [WORD_BITS-1:0]    y_prev_q;
  logic [CW-1:0]           acc_q;
  logic signed [SUMW-1:0]  best_sum_q;
  logic signed [LW-1:0]    best_lag_q;
  logic [LW-1:0]           best_mag_q;
  logic [CW-1:0]           hd_mism_q, hd_ov_q;
  logic [SCORE_W-1:0]      thr_q;
  logic [4:0]              dcnt_q;

  logic                    we_x, we_y;
  logic [AW-1:0]           x_raddr, y_raddr;
  logic [WORD_BITS-1:0]    x_rd, y_rd;
  logic [LW-1:0]           lag_mag;
  logic [CW-1:0]           lo_w, hi_w, ov_w;
  logic [PCW-1:0]          mism_w;
  logic signed [SUMW-1:0]  cur_sum;
  logic [2*CW-1:0]         hd_lhs, hd_rhs;
  logic                    better_corr, better_hd;
  logic                    div_load, div_step;
  logic [SCORE_W-1:0]      quot_w;
  logic signed [SCW-1:0]   sc_wide, sc_sh;
  logic [SCORE_W-1:0]      score_w;

  // key stores, frozen during a sweep
  assign we_x = wr_en_i && !wr_sel_i && !busy_o;
  assign we_y = wr_en_i &&  wr_sel_i && !busy_o;

  assign x_raddr = t_q[AW-1:0] - AW'(1);
  assign y_raddr = t_q[AW-1:0] + AW'(lag_q >>> SW);

  keycorr_bitmem #(.DW(WORD_BITS), .DEPTH(WORDS), .AW(AW)) u_enr_mem (
    .clk(clk), .we(we_x), .waddr(wr_addr_i), .wdata(wr_data_i),
    .raddr(x_raddr), .rdata(x_rd)
  );

  keycorr_bitmem #(.DW(WORD_BITS), .DEPTH(WORDS), .AW(AW)) u_tst_mem (
    .clk(clk), .we(we_y), .waddr(wr_addr_i), .wdata(wr_data_i),
    .raddr(y_raddr), .rdata(y_rd)
  );

  // overlap window of the current offset
  assign lag_mag = mag(lag_q);
  assign lo_w    = (lag_q < 0) ? CW'(lag_mag) : '0;
  assign hi_w    = (lag_q > 0) ? L_CW - CW'(lag_mag) : L_CW;
  assign ov_w    = L_CW - CW'(lag_mag);

  keycorr_lagslice #(.WB(WORD_BITS), .AW(AW), .CW(CW), .SW(SW), .PCW(PCW)) u_slice (
    .x_word(x_rd), .y_hi(y_rd), .y_lo(y_prev_q), .shamt(lag_q[SW-1:0]),
    .w_idx(w_q), .lo(lo_w), .hi(hi_w), .mism(mism_w)
  );

  assign cur_sum     = $signed({2'b00, ov_w}) - $signed({1'b0, acc_q, 1'b0});
  assign better_corr = first_q || (cur_sum > best_sum_q) ||
                       ((cur_sum == best_sum_q) && (lag_mag < best_mag_q));
  assign hd_lhs      = {{CW{1'b0}}, acc_q} * {{CW{1'b0}}, hd_ov_q};
  assign hd_rhs      = {{CW{1'b0}}, hd_mism_q} * {{CW{1'b0}}, ov_w};
  assign better_hd   = first_q || (hd_lhs < hd_rhs);

  assign div_load = (state_q == ST_DIV) && (dcnt_q == 5'd0);
  assign div_step = (state_q == ST_DIV) && (dcnt_q != 5'd0);

  keycorr_fracdiv #(.CW(CW), .QW(SCORE_W)) u_div (
    .clk(clk), .rst(rst), .load(div_load), .step(div_step),
    .num(hd_mism_q), .den(hd_ov_q), .quot(quot_w)
  );

  // Q1.15 scaling of the peak sum with saturation at +1.0
  assign sc_wide = SCW'(best_sum_q) <<< 15;
  assign sc_sh   = sc_wide >>> LOG_L;
  assign score_w = (sc_sh > SAT_HI) ? 16'h7FFF : sc_sh[SCORE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      t_q        <= '0;
      lag_q      <= '0;
      arr_q      <= 1'b0;
      cons_q     <= 1'b0;
      first_q    <= 1'b0;
      w_q        <= '0;
      y_prev_q   <= '0;
      acc_q      <= '0;
      best_sum_q <= '0;
      best_lag_q <= '0;
      best_mag_q <= '0;
      hd_mism_q  <= '0;
      hd_ov_q    <= '0;
      thr_q      <= '0;
      dcnt_q     <= '0;
      busy_o     <= 1'b0;
      valid_o    <= 1'b0;
      auth_o     <= 1'b0;
      score_o    <= '0;
      lag_o      <= '0;
      hd_o       <= '0;
    end else begin
      arr_q   <= (state_q == ST_ISSUE);
      cons_q  <= (state_q == ST_ISSUE) && (t_q != '0);
      w_q     <= x_raddr;
      valid_o <= 1'b0;
      if (arr_q)  y_prev_q <= y_rd;
      if (cons_q) acc_q    <= acc_q + CW'(mism_w);
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_ISSUE;
            t_q     <= '0;
            lag_q   <= LAG_LO;
            thr_q   <= thr_i;
            first_q <= 1'b1;
            acc_q   <= '0;
            busy_o  <= 1'b1;
          end
        end
        ST_ISSUE: begin
          if (t_q == T_LAST) state_q <= ST_DRAIN;
          else               t_q     <= t_q + 1'b1;
        end
        ST_DRAIN: state_q <= ST_CLOSE;
        ST_CLOSE: begin
          if (better_corr) begin
            best_sum_q <= cur_sum;
            best_lag_q <= lag_q;
            best_mag_q <= lag_mag;
          end
          if (better_hd) begin
            hd_mism_q <= acc_q;
            hd_ov_q   <= ov_w;
          end
          first_q <= 1'b0;
          acc_q   <= '0;
          t_q     <= '0;
          if (lag_q == LAG_HI) begin
            state_q <= ST_DIV;
            dcnt_q  <= '0;
          end else begin
            lag_q   <= lag_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_DIV: begin
          dcnt_q <= dcnt_q + 1'b1;
          if (dcnt_q == 5'(DIV_STEPS)) state_q <= ST_FIN;
        end
        ST_FIN: begin
          score_o <= score_w;
          lag_o   <= best_lag_q;
          hd_o    <= quot_w;
          auth_o  <= $signed(score_w) >= $signed(thr_q);
          valid_o <= 1'b1;
          busy_o  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/keycorr_auth_chk.sv
module keycorr_auth_chk #(
  parameter int LW      = 8,
  parameter int MAX_LAG = 72
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          busy_o,
  input logic          valid_o,
  input logic [15:0]   score_o,
  input logic [LW-1:0] lag_o,
  input logic [15:0]   hd_o
);
  // R8: result strobe lasts one cycle
  a_r8_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R8: strobe and busy never overlap
  a_r8_valid_not_busy: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !busy_o);

  // R8: end of a sweep always comes with results
  a_r8_fall_gives_valid: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> valid_o);

  // R8: a sweep only starts on request
  a_r8_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  // R8: results hold between strobes
  a_r8_results_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(score_o) && $stable(lag_o) && $stable(hd_o)));

  // R3: reported offset lies inside the window
  a_r3_lag_window: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((int'($signed(lag_o)) <= MAX_LAG) && (int'($signed(lag_o)) >= -MAX_LAG)));

  // R6: distance never exceeds 1.0
  a_r6_hd_bound: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (hd_o <= 16'h8000));
endmodule

bind keycorr_auth keycorr_auth_chk #(.LW(LW), .MAX_LAG(MAX_LAG)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .valid_o(valid_o),
  .score_o(score_o), .lag_o(lag_o), .hd_o(hd_o)
);

// File: tb/keycorr_auth_bench.sv
`timescale 1ns/1ps
module keycorr_auth_bench;
  localparam int KB  = 1024;
  localparam int ML  = 72;
  localparam int WB  = 32;
  localparam int NW  = KB / WB;
  localparam int AW  = 5;
  localparam int LW  = 8;
  localparam int LAT = (2 * ML + 1) * (NW + 3) + 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en_i = 1'b0, wr_sel_i = 1'b0, start_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [WB-1:0] wr_data_i = '0;
  logic [15:0]   thr_i = '0;
  logic busy_o, valid_o, auth_o;
  logic [15:0] score_o, hd_o;
  logic [LW-1:0] lag_o;

  always #2.5 clk = ~clk;

  keycorr_auth u_keycorr_auth (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .thr_i(thr_i),
    .start_i(start_i), .busy_o(busy_o), .valid_o(valid_o), .auth_o(auth_o),
    .score_o(score_o), .lag_o(lag_o), .hd_o(hd_o)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [KB-1:0] ek, tk;
  int exp_score, exp_lag, exp_hd, exp_auth;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // timing model: counts from the accepted start edge
  logic mbusy = 1'b0, mval = 1'b0;
  int mcnt = 0;
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mbusy = 1'b0; mval = 1'b0; mcnt = 0;
    end else begin
      mval = 1'b0;
      if (mbusy) begin
        mcnt++;
        if (mcnt == LAT) begin mbusy = 1'b0; mval = 1'b1; end
      end else if (start_i) begin
        mbusy = 1'b1; mcnt = 0;
      end
    end
    if (cyc > 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 190000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R8 busy", int'(busy_o), int'(mbusy));
      chk("R8 valid", int'(valid_o), int'(mval));
    end
  end

  function automatic void model(input int thr);
    int best_s, best_m, best_h;
    best_s = 0; best_m = 0; best_h = 0;
    for (int m = -ML; m <= ML; m++) begin
      int mis, ov, s, h, am;
      mis = 0;
      for (int n = 0; n < KB; n++) begin
        int k;
        k = n + m;
        if (k >= 0 && k < KB && ek[n] != tk[k]) mis++;
      end
      am = (m < 0) ? -m : m;
      ov = KB - am;
      s  = ov - 2 * mis;
      h  = (mis * 32768) / ov;
      if (m == -ML || s > best_s || (s == best_s && am < ((best_m < 0) ? -best_m : best_m))) begin
        best_s = s; best_m = m;
      end
      if (m == -ML || h < best_h) best_h = h;
    end
    exp_score = (best_s * 32768) / KB;
    if (exp_score > 32767) exp_score = 32767;
    exp_lag  = best_m;
    exp_hd   = best_h;
    exp_auth = (exp_score >= thr) ? 1 : 0;
  endfunction

  task automatic load_keys();
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < NW; w++) begin
        @(posedge clk); #1;
        wr_en_i = 1'b1; wr_sel_i = s[0]; wr_addr_i = AW'(w);
        wr_data_i = (s == 0) ? ek[w*WB +: WB] : tk[w*WB +: WB];
      end
    end
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic run(input logic signed [15:0] thr, input string tag, input bit disturb);
    model(int'(thr));
    @(posedge clk); #1;
    thr_i = thr; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    if (disturb) begin
      repeat (200) @(posedge clk);
      #1;
      wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_addr_i = AW'(3); wr_data_i = ~tk[3*WB +: WB];
      start_i = 1'b1; thr_i = 16'h8000;
      @(posedge clk); #1;
      wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = ~ek[5*WB +: WB]; wr_addr_i = AW'(5);
      wr_en_i = 1'b1;
      @(posedge clk); #1;
      wr_en_i = 1'b0; start_i = 1'b0;
    end
    @(negedge clk);
    while (!mval) @(negedge clk);
    $display("run %s", tag);
    chk({"R2 R4 score ", tag}, int'($signed(score_o)), exp_score);
    chk({"R3 R5 lag ", tag}, int'($signed(lag_o)), exp_lag);
    chk({"R6 hd ", tag}, int'(hd_o), exp_hd);
    chk({"R7 auth ", tag}, int'(auth_o), exp_auth);
  endtask

  initial begin
    void'($urandom(17));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 busy", int'(busy_o), 0);
    chk("R10 valid", int'(valid_o), 0);
    chk("R10 auth", int'(auth_o), 0);
    chk("R10 score", int'(score_o), 0);
    chk("R10 lag", int'(lag_o), 0);
    chk("R10 hd", int'(hd_o), 0);
    @(posedge clk); #1;
    rst = 1'b0;

    // R1: identical keys
    for (int i = 0; i < KB; i += 32) ek[i +: 32] = $urandom;
    tk = ek;
    load_keys();
    run(16'h2000, "R1 identical", 1'b0);
    chk("R4 identical saturates", int'($signed(score_o)), 32767);
    chk("R3 identical lag", int'($signed(lag_o)), 0);
    chk("R6 identical hd", int'(hd_o), 0);
    run(16'h7FFF, "R7 threshold equal", 1'b0);
    chk("R7 equal threshold authentic", int'(auth_o), 1);

    // drift of +70 and -70 bits
    for (int k = 0; k < KB; k++) tk[k] = (k >= 70) ? ek[k-70] : 1'($urandom);
    load_keys();
    run(16'h2000, "R2 shift +70", 1'b0);
    chk("R3 lag +70", int'($signed(lag_o)), 70);
    run(16'(exp_score + 1), "R7 threshold above", 1'b0);
    chk("R7 above threshold rejected", int'(auth_o), 0);
    for (int k = 0; k < KB; k++) tk[k] = (k < KB - 70) ? ek[k+70] : 1'($urandom);
    load_keys();
    run(16'h2000, "R2 shift -70", 1'b0);
    chk("R3 lag -70", int'($signed(lag_o)), -70);

    // complement key
    tk = ~ek;
    load_keys();
    run(16'h2000, "R7 complement", 1'b0);
    chk("R7 complement rejected", int'(auth_o), 0);

    // unrelated key, with writes and a start during the sweep
    for (int i = 0; i < KB; i += 32) tk[i +: 32] = $urandom;
    load_keys();
    run(16'h2000, "R9 busy writes", 1'b1);
    chk("R9 unrelated rejected", int'(auth_o), 0);

    // equal-magnitude tie at the window edges
    ek = '1;
    tk = '0;
    for (int k = 0; k < 5; k++) begin tk[k] = 1'b1; tk[KB-1-k] = 1'b1; end
    load_keys();
    run(16'h2000, "R5 tie", 1'b0);
    chk("R5 tie picks negative", int'($signed(lag_o)), -72);
    chk("R4 tie score", int'($signed(score_o)), -30144);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule